// File: doc/BRIEF.md
# Vertical Sync Qualifier and Field Classifier

This block sits on the sync path of a video receiver, clocked by the pixel clock. It watches the raw horizontal and vertical sync inputs and produces three things: a cleaned vertical sync, a flag that tells the two interlaced fields apart, and the number of horizontal lines counted between accepted vertical pulses. It drops vertical pulses that are too short or that arrive too soon after the last good one. It also re-times every output vertical edge to the middle of a line, so that the edge is always well clear of a horizontal leading edge.

The field flag depends on where, inside the current line, the vertical leading edge falls. The block measures each line in pixel clocks and splits it into four equal quarters. An edge in one of the two outer quarters marks one field, and an edge in one of the two inner quarters marks the other. With the enable pin low, the vertical input goes straight to the output. In that mode the field flag and the line count hold their values, because neither is meaningful without the filter.

All pins are plain level signals. There is no streaming payload, so no valid/ready handshake and no back-pressure applies. A horizontal leading edge is a rising edge of `hs_in` and a vertical leading edge is a rising edge of `vs_in`. Line length is the number of clocks between two horizontal leading edges.

Top module: `vsync_field_filter`

## Requirements
- R1: A synchronous active-high `rst` clears every counter and forces `field_odd` to 0 and `lines_per_frame` to 0. With the filter on and `vs_in` low, `vs_out` is 0 after reset.
- R2: While `filt_en` is 0, `vs_out` follows `vs_in` combinationally, and `field_odd` and `lines_per_frame` keep their values.
- R3: While `filt_en` is 1, `vs_out` changes only in the cycle after the line position reaches half the latched line length (position = line_len/2). It therefore never changes on a horizontal leading edge for lines of 4 or more clocks.
- R4: A vertical pulse is rejected if `vs_in` is no longer high `line_len` clocks after its leading edge. A pulse of exactly one line or shorter gives no output pulse and no update.
- R5: A vertical pulse is rejected if fewer than `min_lines` horizontal leading edges have been counted since the previous accepted pulse. The first pulse after reset is exempt.
- R6: The position of a vertical edge is the number of clocks since the latest horizontal leading edge, or 0 when both edges arrive in the same cycle. With q = line_len/4 (truncated), an accepted pulse sets `field_odd` to 1 when q ≤ position < line_len − q, and to 0 otherwise.
- R7: `lines_per_frame` reports the number of horizontal leading edges counted from one accepted pulse up to the next. The count is 12 bits wide and saturates at 4095.
- R8: `field_odd` and `lines_per_frame` change only one cycle after a pulse is accepted, and hold through rejected pulses.
- R9: With the filter on, each accepted pulse produces exactly one rising edge on `vs_out`, at the first midpoint after acceptance. `vs_out` falls at the first later midpoint where `vs_in` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| filt_en | input | 1 | Filter enable; 0 passes `vs_in` through |
| min_lines | input | 12 | Minimum line spacing between accepted pulses |
| hs_in | input | 1 | Raw horizontal sync, active high |
| vs_in | input | 1 | Raw vertical sync, active high |
| vs_out | output | 1 | Cleaned, re-timed vertical sync |
| field_odd | output | 1 | Field flag, 1 for an inner-quarter edge |
| lines_per_frame | output | 12 | Lines between the last two accepted pulses |

## Verification
A wrong line counter or a wrong latched length shows up first as the field flag flipping one frame after the fault, and as a `vs_out` edge that leaves the midpoint in the same or the next line. A broken rejection path shows up as an extra `vs_out` pulse within one line of the bad input pulse, and as a line count that is too small at the next frame. A broken saturation or hold path shows up directly in `lines_per_frame` at the next accepted pulse. The bench sweeps every edge position across a 16-clock line and compares each field flag and count against arithmetic on absolute line numbers.

// File: rtl/vsf_pkg.sv
package vsf_pkg;
  parameter int unsigned VSF_PIX_W  = 12;
  parameter int unsigned VSF_LINE_W = 12;

  typedef enum logic {
    FLD_OUTER = 1'b0,
    FLD_INNER = 1'b1
  } field_e;
endpackage

// File: rtl/vsf_line_timer.sv
module vsf_line_timer #(
  parameter int unsigned PIX_W = vsf_pkg::VSF_PIX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hs_in,
  output logic             hs_lead,
  output logic [PIX_W-1:0] line_len,
  output logic             len_ok,
  output logic             mid_hit,
  output logic             pos_mid
);
  localparam logic [PIX_W-1:0] ONE     = PIX_W'(1);
  localparam logic [PIX_W-1:0] MAXV    = '1;
  localparam logic [PIX_W-1:0] MIN_LEN = PIX_W'(4);

  logic             hs_q;
  logic [PIX_W-1:0] pix_cnt;
  logic [PIX_W-1:0] cur_pos;
  logic [PIX_W-1:0] next_len;
  logic [PIX_W-1:0] quarter;

  always_comb begin
    hs_lead  = hs_in && !hs_q;
    next_len = (pix_cnt == MAXV) ? MAXV : pix_cnt + ONE;
    cur_pos  = hs_lead ? '0 : next_len;
    quarter  = line_len >> 2;
    len_ok   = line_len >= MIN_LEN;
    mid_hit  = len_ok && (cur_pos == (line_len >> 1));
    pos_mid  = len_ok && (cur_pos >= quarter) && (cur_pos < (line_len - quarter));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q     <= 1'b0;
      pix_cnt  <= '0;
      line_len <= '0;
    end else begin
      hs_q <= hs_in;
      if (hs_lead) begin
        line_len <= next_len;
        pix_cnt  <= '0;
      end else begin
        pix_cnt  <= next_len;
      end
    end
  end
endmodule

// File: rtl/vsf_qualifier.sv
module vsf_qualifier #(
  parameter int unsigned PIX_W  = vsf_pkg::VSF_PIX_W,
  parameter int unsigned LINE_W = vsf_pkg::VSF_LINE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [LINE_W-1:0] min_lines,
  input  logic              hs_lead,
  input  logic              vs_in,
  input  logic              pos_mid,
  input  logic              len_ok,
  input  logic [PIX_W-1:0]  line_len,
  output logic              accept,
  output logic              field_odd,
  output logic [LINE_W-1:0] lines_per_frame
);
  import vsf_pkg::*;

  localparam logic [LINE_W-1:0] LMAX  = '1;
  localparam logic [LINE_W-1:0] LONE  = LINE_W'(1);
  localparam logic [PIX_W-1:0]  PONE  = PIX_W'(1);

  logic              vs_q;
  logic              vs_lead;
  logic              cand;
  logic [PIX_W-1:0]  wid;
  field_e            cand_fld;
  field_e            fld_q;
  logic [LINE_W-1:0] hcnt;
  logic              have_prev;
  logic              confirm;
  logic              spacing_ok;

  always_comb begin
    vs_lead    = vs_in && !vs_q;
    confirm    = en && cand && vs_in && !vs_lead && (wid >= line_len);
    spacing_ok = !have_prev || (hcnt >= min_lines);
    accept     = confirm && spacing_ok;
    field_odd  = (fld_q == FLD_INNER);
  end

  // Line counter between accepted pulses, saturating
  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt <= '0;
    end else if (accept) begin
      hcnt <= hs_lead ? LONE : '0;
    end else if (hs_lead && (hcnt != LMAX)) begin
      hcnt <= hcnt + LONE;
    end
  end

  // Candidate tracking: position class and width in clocks
  always_ff @(posedge clk) begin
    if (rst) begin
      vs_q     <= 1'b0;
      cand     <= 1'b0;
      wid      <= '0;
      cand_fld <= FLD_OUTER;
    end else begin
      vs_q <= vs_in;
      if (!en) begin
        cand <= 1'b0;
      end else if (vs_lead && len_ok) begin
        cand     <= 1'b1;
        wid      <= PONE;
        cand_fld <= pos_mid ? FLD_INNER : FLD_OUTER;
      end else if (cand) begin
        if (!vs_in || confirm) begin
          cand <= 1'b0;
        end else begin
          wid <= wid + PONE;
        end
      end
    end
  end

  // Reported values move only on acceptance
  always_ff @(posedge clk) begin
    if (rst) begin
      fld_q           <= FLD_OUTER;
      lines_per_frame <= '0;
      have_prev       <= 1'b0;
    end else if (accept) begin
      fld_q           <= cand_fld;
      lines_per_frame <= hcnt;
      have_prev       <= 1'b1;
    end
  end
endmodule

// File: rtl/vsf_out_stage.sv
module vsf_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic vs_in,
  input  logic accept,
  input  logic mid_hit,
  output logic vs_out
);
  logic armed;
  logic vs_flt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      armed  <= 1'b0;
      vs_flt <= 1'b0;
    end else begin
      if (accept) begin
        armed <= 1'b1;
      end else if (mid_hit && armed) begin
        armed <= 1'b0;
      end
      if (mid_hit) begin
        if (armed) begin
          vs_flt <= 1'b1;
        end else if (!vs_in) begin
          vs_flt <= 1'b0;
        end
      end
    end
  end

  assign vs_out = en ? vs_flt : vs_in;
endmodule

// File: rtl/vsync_field_filter.sv
module vsync_field_filter #(
  parameter int unsigned PIX_W  = vsf_pkg::VSF_PIX_W,
  parameter int unsigned LINE_W = vsf_pkg::VSF_LINE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              filt_en,
  input  logic [LINE_W-1:0] min_lines,
  input  logic              hs_in,
  input  logic              vs_in,
  output logic              vs_out,
  output logic              field_odd,
  output logic [LINE_W-1:0] lines_per_frame
);
  logic             hs_lead;
  logic [PIX_W-1:0] line_len;
  logic             len_ok;
  logic             mid_hit;
  logic             pos_mid;
  logic             accept;

  vsf_line_timer #(.PIX_W(PIX_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .hs_in    (hs_in),
    .hs_lead  (hs_lead),
    .line_len (line_len),
    .len_ok   (len_ok),
    .mid_hit  (mid_hit),
    .pos_mid  (pos_mid)
  );

  vsf_qualifier #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_qual (
    .clk             (clk),
    .rst             (rst),
    .en              (filt_en),
    .min_lines       (min_lines),
    .hs_lead         (hs_lead),
    .vs_in           (vs_in),
    .pos_mid         (pos_mid),
    .len_ok          (len_ok),
    .line_len        (line_len),
    .accept          (accept),
    .field_odd       (field_odd),
    .lines_per_frame (lines_per_frame)
  );

  vsf_out_stage u_out (
    .clk     (clk),
    .rst     (rst),
    .en      (filt_en),
    .vs_in   (vs_in),
    .accept  (accept),
    .mid_hit (mid_hit),
    .vs_out  (vs_out)
  );
endmodule

// File: rtl/vsf_checker.sv
module vsf_checker #(
  parameter int unsigned LINE_W = vsf_pkg::VSF_LINE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              filt_en,
  input logic              vs_in,
  input logic              vs_out,
  input logic              field_odd,
  input logic              mid_hit,
  input logic              accept,
  input logic [LINE_W-1:0] lines_per_frame
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!field_odd && (lines_per_frame == '0)));

  assert_no_accept_off_R2: assert property (@(posedge clk) disable iff (rst)
    !filt_en |-> !accept);

  assert_edge_at_mid_R3: assert property (@(posedge clk) disable iff (rst)
    (filt_en && $past(filt_en) && !$stable(vs_out)) |-> $past(mid_hit));

  assert_update_needs_vs_R8: assert property (@(posedge clk) disable iff (rst)
    (!$stable(field_odd) || !$stable(lines_per_frame)) |-> ($past(vs_in) && $past(filt_en)));

  assert_fall_needs_low_R9: assert property (@(posedge clk) disable iff (rst)
    (filt_en && $past(filt_en) && $fell(vs_out)) |-> !$past(vs_in));
endmodule

bind vsync_field_filter vsf_checker #(.LINE_W(LINE_W)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .filt_en         (filt_en),
  .vs_in           (vs_in),
  .vs_out          (vs_out),
  .field_odd       (field_odd),
  .mid_hit         (mid_hit),
  .accept          (accept),
  .lines_per_frame (lines_per_frame)
);

// File: tb/sim_vsync_field_filter.sv
module sim_vsync_field_filter;
  localparam int L    = 16;
  localparam int N    = 10;
  localparam int W    = L + 4;
  localparam int MINL = 5;
  localparam int LMAX = 4095;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        filt_en = 1'b1;
  logic [11:0] min_lines = 12'(MINL);
  logic        hs_in = 1'b0;
  logic        vs_in = 1'b0;
  logic        vs_out;
  logic        field_odd;
  logic [11:0] lines_per_frame;

  always #10 clk = ~clk;

  vsync_field_filter u0 (
    .clk (clk), .rst (rst), .filt_en (filt_en), .min_lines (min_lines),
    .hs_in (hs_in), .vs_in (vs_in), .vs_out (vs_out),
    .field_odd (field_odd), .lines_per_frame (lines_per_frame)
  );

  int checks = 0, errors = 0;
  int abs_line = -1, prev_x = 0;
  logic last_vs = 1'b0;
  int bad_edges = 0, rises = 0, pass_mism = 0;
  int acc_line = 0, acc_p = 0, exp_acc = 0, exp_lines = 0;
  bit have_acc = 0, lines_known = 0, exp_field = 0, done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input bit h, input bit v, input int x);
    @(negedge clk);
    if (filt_en && (vs_out !== last_vs)) begin
      if (prev_x != L / 2) bad_edges++;
      if (vs_out) rises++;
    end
    hs_in  = h;
    vs_in  = v;
    prev_x = x;
    #1;
    if (!filt_en && (vs_out !== vs_in)) pass_mism++;
    last_vs = vs_out;
  endtask

  task automatic idle_lines(input int n);
    for (int l = 0; l < n; l++) begin
      for (int x = 0; x < L; x++) begin
        if (x == 0) abs_line++;
        cyc(x < 2, 1'b0, x);
      end
    end
  endtask

  task automatic frame(input int p, input int nl, input int w, input bit acc);
    int start;
    int a;
    int n;
    start = abs_line + 1;
    for (int l = 0; l < nl; l++) begin
      for (int x = 0; x < L; x++) begin
        int t;
        t = l * L + x;
        if (x == 0) abs_line++;
        cyc(x < 2, (t >= p) && (t < p + w), x);
      end
    end
    if (acc) begin
      a = start + 1;
      if (have_acc) begin
        n = a - acc_line + 1 - ((p == 0) ? 1 : 0) - ((acc_p > 0) ? 1 : 0);
        exp_lines = (n > LMAX) ? LMAX : n;
        lines_known = 1;
      end
      exp_field = (p >= L / 4) && (p < L - L / 4);
      acc_line = a;
      acc_p = p;
      have_acc = 1;
      exp_acc++;
    end
  endtask

  task automatic check_outputs(input string rf, input string rl);
    chk(field_odd == exp_field, rf, int'(field_odd), int'(exp_field));
    if (lines_known) chk(int'(lines_per_frame) == exp_lines, rl, int'(lines_per_frame), exp_lines);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk(field_odd == 1'b0, "R1 field", int'(field_odd), 0);
    chk(lines_per_frame == 12'd0, "R1 lines", int'(lines_per_frame), 0);
    chk(vs_out == 1'b0, "R1 vs_out", int'(vs_out), 0);

    idle_lines(3);
    frame(0, N, W, 1);
    check_outputs("R6 first field", "R7 first");

    // R6/R7 sweep of every edge position in the line
    for (int p = 0; p < L; p++) begin
      frame(p, N, W, 1);
      check_outputs("R6 field sweep", "R7 lines sweep");
    end

    // R4 pulse of exactly one line is rejected; R8 outputs hold
    frame(4, N, L, 0);
    check_outputs("R4 R8 field hold", "R4 R8 lines hold");
    frame(4, N, W, 1);
    check_outputs("R6 after width reject", "R7 after width reject");

    // R5 pulse too soon after the previous accepted pulse
    frame(4, 3, W, 1);
    check_outputs("R6 short frame", "R7 short frame");
    frame(14, N, W, 0);
    check_outputs("R5 field hold", "R5 lines hold");
    frame(14, N, W, 1);
    check_outputs("R5 field next", "R5 lines next");

    // R2 filter off: passthrough, outputs hold
    filt_en = 1'b0;
    frame(6, N, W, 0);
    chk(pass_mism == 0, "R2 passthrough", pass_mism, 0);
    check_outputs("R2 field hold", "R2 lines hold");
    filt_en = 1'b1;
    frame(6, N, W, 1);
    check_outputs("R6 after enable", "R7 after enable");

    // R7 saturation
    frame(5, 4100, W, 1);
    check_outputs("R6 long frame", "R7 long frame");
    frame(5, N, W, 1);
    check_outputs("R6 sat field", "R7 saturation");

    idle_lines(3);
    chk(bad_edges == 0, "R3 edges off midpoint", bad_edges, 0);
    chk(rises == exp_acc, "R9 one rise per accepted pulse", rises, exp_acc);
    chk(vs_out == 1'b0, "R9 output low after input low", int'(vs_out), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule